// File: doc/BRIEF.md
# Load/Store Unit with Memory-Mapped Serial Window

This block handles the memory side of integer load and store instructions. Each request carries an effective address, a three-bit size/sign code, store data and a read/write flag. The block checks the request, sends it to a little-endian word RAM or to a small serial-transmitter register window, and returns one response per request: a load value extended to 32 bits, or an error flag.

RAM accesses go out as a word address, four byte-lane write enables and lane-steered write data. The RAM is expected to return read data one clock after the request. Writes to the serial window's transmit offset raise a one-cycle valid pulse with the character on a byte output. A read of the status offset returns the transmitter-ready bit. Misaligned, unmapped and unsupported requests are refused with an error, and nothing is written.

Top module: `lsu_mmio`

## Requirements
- R1: Byte loads (code 0 signed, code 4 unsigned) return the byte at address bits [1:0] in bits [7:0]. Code 0 copies bit 7 into bits [31:8]. Code 4 fills bits [31:8] with zeros.
- R2: Halfword loads (code 1 signed, code 5 unsigned) return the halfword at an even address. Code 1 copies bit 15 into bits [31:16]. Code 5 fills bits [31:16] with zeros.
- R3: Word loads (code 2) return the RAM word as stored, little-endian: the byte at the lowest address sits in bits [7:0].
- R4: A byte store (code 0) drives exactly one lane enable, 4'b0001 shifted left by address[1:0]. The low data byte is replicated into all four lanes of the write data.
- R5: A halfword store (code 1) enables lanes 4'b0011 at address[1]=0 or 4'b1100 at address[1]=1, with the low halfword replicated into both halves. A word store (code 2) enables 4'b1111 with the data unchanged.
- R6: A halfword access at an odd address, or a word access at an address not a multiple of 4, reports an error, returns zero and writes neither RAM nor the serial window.
- R7: An address outside both RAM (base RAM_BASE, RAM_BYTES long) and the serial window (0x10000000 to 0x10000FFF) reports an error, returns zero on loads and writes nothing.
- R8: An aligned store to serial offset 0 pulses tx_valid for one cycle, one clock after the request, with the store data's low byte on tx_data and no error. A store to any other window offset is ignored without error.
- R9: A load covering serial offset 5 returns a status byte in that byte's lane. Its bit 0 equals tx_ready as sampled in the request cycle.
- R10: Codes other than 0, 1, 2, 4 and 5 for loads, and other than 0, 1 and 2 for stores, report an error and perform no access.
- R11: Every request gets exactly one response (resp_valid with resp_data and resp_err) one clock later. In reset, resp_valid, resp_err, resp_data and tx_valid are all zero.
- R12: ram_req is high only in the request cycle of a legal RAM access. ram_word_addr is then address bits [RAM_AW+1:2] of the offset from RAM_BASE, and ram_be is zero for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_funct3 | input | 3 | Size/sign code |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| ram_req | output | 1 | RAM access this cycle |
| ram_be | output | 4 | RAM byte-lane write enables |
| ram_word_addr | output | RAM_AW | RAM word index |
| ram_wdata | output | 32 | Lane-steered store data |
| ram_rdata | input | 32 | RAM read word, one clock after ram_req |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_valid | output | 1 | Character strobe |
| tx_data | output | 8 | Transmitted character |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 32 | Extended load value, zero otherwise |
| resp_err | output | 1 | Request was refused |

## Verification
Two functions overlap in one cycle when requests arrive back to back. The response to a serial-window store, with its transmit pulse, appears in the same cycle that the next request drives RAM lane enables or loads. The bench issues a transmit store followed at once by a RAM load, and a RAM store followed at once by a refused store. The transmit byte, the lane enables and the later response are each compared against separate expected queues, so a pulse that is lost, duplicated or mixed with the neighbouring response is caught. A read-back of RAM after the refused stores shows that they left no trace.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_UART = 2'd2
    } target_e;

    // Request context carried from the request cycle into the response cycle
    typedef struct packed {
        logic        valid;
        logic        write;
        logic [2:0]  f3;
        logic [1:0]  lane;
        target_e     tgt;
        logic        err;
        logic        stat_hit;
    } req_meta_t;

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lane);
        logic [LANES-1:0] m;
        case (sz)
            2'b00:   m = 4'b0001 << lane;
            2'b01:   m = lane[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic size_legal(input logic wr, input logic [2:0] f3);
        logic ok;
        if (wr) ok = (f3 == 3'd0) || (f3 == 3'd1) || (f3 == 3'd2);
        else    ok = (f3 == 3'd0) || (f3 == 3'd1) || (f3 == 3'd2) || (f3 == 3'd4) || (f3 == 3'd5);
        return ok;
    endfunction

    function automatic logic is_aligned(input logic [1:0] sz, input logic [1:0] lane);
        logic ok;
        case (sz)
            2'b01:   ok = !lane[0];
            2'b10:   ok = (lane == 2'b00);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic [XLEN-1:0] extend_load(input logic [2:0] f3,
                                                    input logic [XLEN-1:0] word,
                                                    input logic [1:0] lane);
        logic [XLEN-1:0] s;
        logic [XLEN-1:0] r;
        s = word >> {lane, 3'b000};
        case (f3)
            3'd0:    r = {{24{s[7]}}, s[7:0]};
            3'd1:    r = {{16{s[15]}}, s[15:0]};
            3'd4:    r = {24'd0, s[7:0]};
            3'd5:    r = {16'd0, s[15:0]};
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter logic [31:0] RAM_BASE   = 32'h0000_0000,
    parameter logic [31:0] RAM_BYTES  = 32'd65536,
    parameter logic [31:0] UART_BASE  = 32'h1000_0000,
    parameter logic [31:0] UART_BYTES = 32'd4096,
    parameter int          RAM_AW     = 14,
    parameter int          UART_OW    = 12
) (
    input  logic                valid,
    input  logic                write,
    input  logic [2:0]          f3,
    input  logic [31:0]         addr,
    output target_e             tgt,
    output logic                err,
    output logic [RAM_AW-1:0]   ram_word,
    output logic [UART_OW-1:0]  uart_off
);
    logic [31:0] ram_off;
    logic [31:0] uart_off_full;
    logic        in_ram;
    logic        in_uart;

    // Subtraction wraps for addresses below a base, so one compare bounds each window
    assign ram_off       = addr - RAM_BASE;
    assign uart_off_full = addr - UART_BASE;
    assign in_ram        = ram_off < RAM_BYTES;
    assign in_uart       = uart_off_full < UART_BYTES;

    always_comb begin
        if (in_ram)       tgt = TGT_RAM;
        else if (in_uart) tgt = TGT_UART;
        else              tgt = TGT_NONE;
    end

    assign err = valid && (!size_legal(write, f3) ||
                           !is_aligned(f3[1:0], addr[1:0]) ||
                           (tgt == TGT_NONE));

    assign ram_word = ram_off[RAM_AW+1:2];
    assign uart_off = uart_off_full[UART_OW-1:0];
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  logic              en,
    input  logic [1:0]        sz,
    input  logic [1:0]        lane,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [LANES-1:0]  be,
    output logic [XLEN-1:0]   wdata_o
);
    assign be = en ? lane_mask(sz, lane) : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata_o[8*g +: 8] = (sz == 2'b00) ? wdata_i[7:0] :
                                   (sz == 2'b01) ? wdata_i[8*(g%2) +: 8] :
                                                   wdata_i[8*g +: 8];
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
(
    input  logic              live,
    input  logic [2:0]        f3,
    input  logic [1:0]        lane,
    input  logic [XLEN-1:0]   word,
    output logic [XLEN-1:0]   data
);
    assign data = live ? extend_load(f3, word, lane) : '0;
endmodule

// File: rtl/lsu_uart_port.sv
module lsu_uart_port
    import lsu_pkg::*;
#(
    parameter int          UART_OW   = 12,
    parameter logic [31:0] TX_OFF    = 32'd0,
    parameter logic [31:0] STAT_OFF  = 32'd5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_en,
    input  logic                acc_write,
    input  logic [UART_OW-1:0]  acc_off,
    input  logic [7:0]          acc_wbyte,
    input  logic                tx_ready,
    output logic                stat_hit,
    output logic [XLEN-1:0]     stat_word,
    output logic                tx_valid,
    output logic [7:0]          tx_data
);
    localparam logic [UART_OW-1:0] TX_OFF_V   = TX_OFF[UART_OW-1:0];
    localparam logic [UART_OW-1:0] STAT_OFF_V = STAT_OFF[UART_OW-1:0];
    localparam logic [1:0]         STAT_LANE  = STAT_OFF[1:0];

    logic tx_fire;
    logic stat_q;

    assign tx_fire  = acc_en && acc_write && (acc_off == TX_OFF_V);
    assign stat_hit = acc_en && !acc_write && (acc_off[UART_OW-1:2] == STAT_OFF_V[UART_OW-1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            stat_q   <= 1'b0;
        end else begin
            tx_valid <= tx_fire;
            stat_q   <= tx_ready;
            if (tx_fire) tx_data <= acc_wbyte;
        end
    end

    // Status byte placed in its lane so the common load extension applies
    assign stat_word = {{(XLEN-1){1'b0}}, stat_q} << {STAT_LANE, 3'b000};
endmodule

// File: rtl/lsu_mmio.sv
module lsu_mmio
    import lsu_pkg::*;
#(
    parameter logic [31:0] RAM_BASE   = 32'h0000_0000,
    parameter logic [31:0] RAM_BYTES  = 32'd65536,
    parameter logic [31:0] UART_BASE  = 32'h1000_0000,
    parameter logic [31:0] UART_BYTES = 32'd4096,
    parameter logic [31:0] TX_OFF     = 32'd0,
    parameter logic [31:0] STAT_OFF   = 32'd5,
    localparam int         RAM_AW     = $clog2(RAM_BYTES) - 2,
    localparam int         UART_OW    = $clog2(UART_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2:0]         req_funct3,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               ram_req,
    output logic [3:0]         ram_be,
    output logic [RAM_AW-1:0]  ram_word_addr,
    output logic [31:0]        ram_wdata,
    input  logic [31:0]        ram_rdata,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               resp_valid,
    output logic [31:0]        resp_data,
    output logic               resp_err
);
    target_e               tgt;
    logic                  dec_err;
    logic [UART_OW-1:0]    uart_off;
    logic                  go;
    logic                  stat_hit;
    logic [XLEN-1:0]       stat_word;
    logic [XLEN-1:0]       raw_word;
    logic                  live;
    req_meta_t             meta_d;
    req_meta_t             meta_q;

    lsu_decode #(
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES),
        .UART_BASE  (UART_BASE),
        .UART_BYTES (UART_BYTES),
        .RAM_AW     (RAM_AW),
        .UART_OW    (UART_OW)
    ) u_decode (
        .valid    (req_valid),
        .write    (req_write),
        .f3       (req_funct3),
        .addr     (req_addr),
        .tgt      (tgt),
        .err      (dec_err),
        .ram_word (ram_word_addr),
        .uart_off (uart_off)
    );

    assign go      = req_valid && !dec_err;
    assign ram_req = go && (tgt == TGT_RAM);

    lsu_store_lanes u_lanes (
        .en      (ram_req && req_write),
        .sz      (req_funct3[1:0]),
        .lane    (req_addr[1:0]),
        .wdata_i (req_wdata),
        .be      (ram_be),
        .wdata_o (ram_wdata)
    );

    lsu_uart_port #(
        .UART_OW  (UART_OW),
        .TX_OFF   (TX_OFF),
        .STAT_OFF (STAT_OFF)
    ) u_uart (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (go && (tgt == TGT_UART)),
        .acc_write (req_write),
        .acc_off   (uart_off),
        .acc_wbyte (req_wdata[7:0]),
        .tx_ready  (tx_ready),
        .stat_hit  (stat_hit),
        .stat_word (stat_word),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    always_comb begin
        meta_d.valid    = req_valid;
        meta_d.write    = req_write;
        meta_d.f3       = req_funct3;
        meta_d.lane     = req_addr[1:0];
        meta_d.tgt      = dec_err ? TGT_NONE : tgt;
        meta_d.err      = dec_err;
        meta_d.stat_hit = stat_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) meta_q <= '0;
        else     meta_q <= meta_d;
    end

    always_comb begin
        case (meta_q.tgt)
            TGT_RAM:  raw_word = ram_rdata;
            TGT_UART: raw_word = meta_q.stat_hit ? stat_word : '0;
            default:  raw_word = '0;
        endcase
    end

    assign live = meta_q.valid && !meta_q.err && !meta_q.write;

    lsu_load_align u_align (
        .live (live),
        .f3   (meta_q.f3),
        .lane (meta_q.lane),
        .word (raw_word),
        .data (resp_data)
    );

    assign resp_valid = meta_q.valid;
    assign resp_err   = meta_q.valid && meta_q.err;
endmodule

// File: rtl/lsu_mmio_chk.sv
module lsu_mmio_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_funct3,
    input logic [31:0] req_addr,
    input logic        ram_req,
    input logic [3:0]  ram_be,
    input logic        tx_valid,
    input logic        resp_valid,
    input logic [31:0] resp_data,
    input logic        resp_err
);
    // R11: one response per request, one clock later
    p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    p_no_resp_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R4: byte stores touch a single lane
    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_req && req_write && req_funct3[1:0] == 2'b00) |-> $countones(ram_be) == 1);

    // R5: halfword stores use one aligned lane pair
    p_half_lane_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_req && req_write && req_funct3[1:0] == 2'b01) |-> (ram_be == 4'b0011 || ram_be == 4'b1100));

    // R6: RAM only sees aligned accesses
    p_ram_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> ((req_funct3[1:0] != 2'b10 || req_addr[1:0] == 2'b00) &&
                     (req_funct3[1:0] != 2'b01 || !req_addr[0])));

    // R12: loads write no lanes, idle cycles make no RAM access
    p_no_lanes_on_load_r12: assert property (@(posedge clk) disable iff (rst)
        (ram_req && !req_write) |-> ram_be == 4'b0000);
    p_quiet_when_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!ram_req && ram_be == 4'b0000));

    // R7: a refused request returns zero
    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && resp_data == 32'd0));

    // R8: a transmit pulse comes from an accepted store
    p_tx_from_store_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (resp_valid && !resp_err && $past(req_write)));
endmodule

bind lsu_mmio lsu_mmio_chk u_chk (.*);

// File: tb/tb_lsu_mmio.sv
module tb_lsu_mmio;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_funct3 = 3'd0;
    logic [31:0] req_addr = 32'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        ram_req;
    logic [3:0]  ram_be;
    logic [AW-1:0] ram_word_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = 32'd0;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        resp_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t        resp_q[$];
    logic [7:0]  tx_q[$];
    logic [31:0] mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_mmio #(.RAM_BYTES(32'd1024)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_funct3(req_funct3),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ram_req(ram_req), .ram_be(ram_be), .ram_word_addr(ram_word_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err)
    );

    // Synchronous RAM model: read-before-write, data one clock after ram_req
    initial for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    always @(posedge clk) begin
        if (ram_req) begin
            ram_rdata <= mem[ram_word_addr];
            for (int b = 0; b < 4; b++)
                if (ram_be[b]) mem[ram_word_addr][8*b +: 8] <= ram_wdata[8*b +: 8];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares responses and transmit pulses against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (resp_valid) begin
                if (resp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected response", resp_data, 32'd0);
                end else begin
                    exp_t e;
                    e = resp_q.pop_front();
                    check(resp_err == e.err, {e.tag, " err"}, {31'd0, resp_err}, {31'd0, e.err});
                    check(resp_data == e.data, {e.tag, " data"}, resp_data, e.data);
                end
            end
            if (tx_valid) begin
                if (tx_q.size() == 0) begin
                    check(1'b0, "R8 unexpected tx pulse", {24'd0, tx_data}, 32'd0);
                end else begin
                    logic [7:0] t;
                    t = tx_q.pop_front();
                    check(tx_data == t, "R8 tx byte", {24'd0, tx_data}, {24'd0, t});
                end
            end
        end
    end

    // Driver: called at a falling edge, holds the request for one cycle
    task automatic issue(input bit w, input logic [2:0] f3, input logic [31:0] a, input logic [31:0] wd,
                         input logic [31:0] exp_data, input bit exp_err,
                         input bit exp_ram, input logic [3:0] exp_be, input logic [31:0] exp_wd,
                         input string tag);
        exp_t e;
        req_valid = 1'b1; req_write = w; req_funct3 = f3; req_addr = a; req_wdata = wd;
        e.data = exp_data; e.err = exp_err; e.tag = tag;
        resp_q.push_back(e);
        #1;
        check(ram_req == exp_ram, {tag, " ram_req"}, {31'd0, ram_req}, {31'd0, exp_ram});
        check(ram_be == exp_be, {tag, " lanes"}, {28'd0, ram_be}, {28'd0, exp_be});
        if (exp_ram)
            check(ram_word_addr == a[9:2], {tag, " word addr R12"}, {24'd0, ram_word_addr}, {24'd0, a[9:2]});
        if (exp_be != 4'b0000)
            check(ram_wdata == exp_wd, {tag, " wdata"}, ram_wdata, exp_wd);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0; req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(resp_valid == 1'b0, "R11 reset resp_valid", {31'd0, resp_valid}, 32'd0);
        check(resp_err == 1'b0, "R11 reset resp_err", {31'd0, resp_err}, 32'd0);
        check(resp_data == 32'd0, "R11 reset resp_data", resp_data, 32'd0);
        check(tx_valid == 1'b0, "R11 reset tx_valid", {31'd0, tx_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R5 word store, R3 word load
        issue(1, 3'd2, 32'h100, 32'h8899AABB, 0, 0, 1, 4'b1111, 32'h8899AABB, "R5 sw 0x100");
        issue(1, 3'd2, 32'h104, 32'h00000000, 0, 0, 1, 4'b1111, 32'h0, "R5 sw 0x104");
        issue(0, 3'd2, 32'h100, 0, 32'h8899AABB, 0, 1, 4'b0000, 0, "R3 lw 0x100");
        // R1 byte loads
        issue(0, 3'd0, 32'h100, 0, 32'hFFFFFFBB, 0, 1, 4'b0000, 0, "R1 lb 0x100");
        issue(0, 3'd0, 32'h101, 0, 32'hFFFFFFAA, 0, 1, 4'b0000, 0, "R1 lb 0x101");
        issue(0, 3'd0, 32'h102, 0, 32'hFFFFFF99, 0, 1, 4'b0000, 0, "R1 lb 0x102");
        issue(0, 3'd4, 32'h103, 0, 32'h00000088, 0, 1, 4'b0000, 0, "R1 lbu 0x103");
        // R2 halfword loads
        issue(0, 3'd1, 32'h102, 0, 32'hFFFF8899, 0, 1, 4'b0000, 0, "R2 lh 0x102");
        issue(0, 3'd5, 32'h100, 0, 32'h0000AABB, 0, 1, 4'b0000, 0, "R2 lhu 0x100");
        issue(0, 3'd1, 32'h100, 0, 32'hFFFFAABB, 0, 1, 4'b0000, 0, "R2 lh 0x100");
        // R4 byte store, R5 halfword store
        issue(1, 3'd0, 32'h105, 32'h123456C3, 0, 0, 1, 4'b0010, 32'hC3C3C3C3, "R4 sb 0x105");
        issue(1, 3'd1, 32'h106, 32'h0000BEEF, 0, 0, 1, 4'b1100, 32'hBEEFBEEF, "R5 sh 0x106");
        issue(0, 3'd2, 32'h104, 0, 32'hBEEFC300, 0, 1, 4'b0000, 0, "R4 R5 lw 0x104");
        // R6 misaligned
        issue(1, 3'd2, 32'h102, 32'hFFFFFFFF, 0, 1, 0, 4'b0000, 0, "R6 sw 0x102");
        issue(1, 3'd1, 32'h103, 32'hFFFFFFFF, 0, 1, 0, 4'b0000, 0, "R6 sh 0x103");
        issue(0, 3'd1, 32'h101, 0, 0, 1, 0, 4'b0000, 0, "R6 lh 0x101");
        issue(0, 3'd2, 32'h100, 0, 32'h8899AABB, 0, 1, 4'b0000, 0, "R6 word untouched");
        // R7 unmapped
        issue(1, 3'd2, 32'h400, 32'h11111111, 0, 1, 0, 4'b0000, 0, "R7 sw 0x400");
        issue(0, 3'd2, 32'h400, 0, 0, 1, 0, 4'b0000, 0, "R7 lw 0x400");
        issue(0, 3'd2, 32'h20000000, 0, 0, 1, 0, 4'b0000, 0, "R7 lw far");
        // R8 serial transmit, back to back with RAM load
        tx_q.push_back(8'h41);
        issue(1, 3'd0, 32'h10000000, 32'h00000041, 0, 0, 0, 4'b0000, 0, "R8 sb tx");
        issue(0, 3'd2, 32'h104, 0, 32'hBEEFC300, 0, 1, 4'b0000, 0, "R8 lw beside tx");
        tx_q.push_back(8'h48);
        issue(1, 3'd2, 32'h10000000, 32'h12345648, 0, 0, 0, 4'b0000, 0, "R8 sw tx");
        issue(1, 3'd0, 32'h10000001, 32'h00000055, 0, 0, 0, 4'b0000, 0, "R8 sb other offset");
        issue(1, 3'd1, 32'h10000001, 32'h00000066, 0, 1, 0, 4'b0000, 0, "R6 R8 sh misaligned tx");
        idle(2);
        check(tx_q.size() == 0, "R8 tx pulses delivered", tx_q.size(), 0);
        // R9 status reads
        tx_ready = 1'b1;
        issue(0, 3'd4, 32'h10000005, 0, 32'h00000001, 0, 0, 4'b0000, 0, "R9 lbu status ready");
        tx_ready = 1'b0;
        issue(0, 3'd0, 32'h10000005, 0, 32'h00000000, 0, 0, 4'b0000, 0, "R9 lb status busy");
        tx_ready = 1'b1;
        issue(0, 3'd2, 32'h10000004, 0, 32'h00000100, 0, 0, 4'b0000, 0, "R9 lw status word");
        issue(0, 3'd4, 32'h10000000, 0, 32'h00000000, 0, 0, 4'b0000, 0, "R9 lbu tx offset");
        // R10 unsupported codes, store then refused store back to back
        issue(0, 3'd3, 32'h100, 0, 0, 1, 0, 4'b0000, 0, "R10 load code 3");
        issue(1, 3'd0, 32'h108, 32'h0000005A, 0, 0, 1, 4'b0001, 32'h5A5A5A5A, "R4 sb 0x108");
        issue(1, 3'd4, 32'h104, 32'h00000000, 0, 1, 0, 4'b0000, 0, "R10 store code 4");
        issue(1, 3'd5, 32'h104, 32'h00000000, 0, 1, 0, 4'b0000, 0, "R10 store code 5");
        issue(0, 3'd2, 32'h104, 0, 32'hBEEFC300, 0, 1, 4'b0000, 0, "R10 word untouched");
        issue(0, 3'd2, 32'h108, 0, 32'h0000005A, 0, 1, 4'b0000, 0, "R4 lw 0x108");
        idle(3);
        check(resp_q.size() == 0, "R11 all responses seen", resp_q.size(), 0);
        check(tx_q.size() == 0, "R8 no tx left", tx_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule